// File: doc/BRIEF.md
# Reset-Cause and Break-Wake Status Unit

This unit keeps two byte-wide status registers on a small synchronous bus. The reset-cause register records which reset sources have fired since software last looked. Each source reaches the unit as a one-cycle event pulse. A power-on event starts the record afresh, and every other source adds its own flag to whatever is already there. Reading the register returns its contents and then empties it, so the next read shows only the causes that arrived after the last one.

The break-wake register holds one flag. The flag is raised when a break interrupt pulls the processor out of its low-power wait state. Software clears it by writing a zero into the flag's bit position.

Both registers share one address window. Read data is combinational: it is valid in the same cycle as the read strobe. Any side effect of the access takes place at the next rising clock edge.

Top module: `rst_brk_status`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it is released, the reset-cause register holds 8'h80 and the break-wake register holds 8'h00.
- R2: The break-wake register is at address `BASE_ADDR` and the reset-cause register is at `BASE_ADDR+1`. `bus_rdata` shows the addressed register in the cycle `bus_rd` is high. It is 8'h00 when `bus_rd` is low or the address is outside those two. A read of an unmapped address changes no state.
- R3: The reset-cause bit positions are: 7 power-on, 6 external pin, 5 watchdog, 4 illegal opcode, 3 illegal address, 2 mode-select, 1 low-voltage. Bit 0 always reads 0.
- R4: A power-on event sets bit 7 and clears every other bit. Any other source pulsed in the same cycle is also set, so power-on together with low-voltage gives 8'h82.
- R5: Any non-power-on event sets only its own bit. Bits already set stay set, so flags accumulate across events.
- R6: A read of the reset-cause register clears the whole register at the following clock edge. A source event in the same cycle as that read is kept in the register after the clear.
- R7: Writes to the reset-cause register have no effect.
- R8: A break-wake event sets bit 1 of the break-wake register. Its other bits always read 0.
- R9: A write to the break-wake register with bit 1 equal to 0 clears the flag. A write with bit 1 equal to 1 leaves the flag unchanged. A break-wake event in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_por | input | 1 | Power-on reset event pulse |
| ev_pin | input | 1 | External reset pin event pulse |
| ev_wdog | input | 1 | Watchdog timeout reset event pulse |
| ev_ilop | input | 1 | Illegal opcode reset event pulse |
| ev_iladdr | input | 1 | Illegal address reset event pulse |
| ev_modesel | input | 1 | Mode-select reset event pulse |
| ev_lowv | input | 1 | Low-voltage reset event pulse |
| ev_brk_wait | input | 1 | Break interrupt ended wait state |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |

## Verification
A read returns its value in the cycle the strobe is high. Event pulses, clearing reads and writes change the registers at the next rising edge, so their effect first appears in a read one cycle later. The driver applies each stimulus for exactly one cycle, starting just after a rising edge. Whenever a read is expected, it pushes the expected byte onto a queue. The monitor samples `bus_rdata` at the falling edge of that same cycle, before the edge that applies any clear, and compares it with the head of the queue. As a result, every check sees the state left by all earlier cycles and none of the current cycle's effects.

// File: rtl/rst_stat_pkg.sv
package rst_stat_pkg;
  localparam int DATA_W = 8;
  localparam int SRC_N  = 7;

  // source index inside the event vector; register bit = index + 1
  localparam int SRC_LOWV    = 0;
  localparam int SRC_MODESEL = 1;
  localparam int SRC_ILADDR  = 2;
  localparam int SRC_ILOP    = 3;
  localparam int SRC_WDOG    = 4;
  localparam int SRC_PIN     = 5;
  localparam int SRC_POR     = 6;

  localparam int BRK_BIT = 1;

  typedef logic [SRC_N-1:0]  src_vec_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/rst_src_flags.sv
module rst_src_flags
  import rst_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t src_ev,
  input  logic     clr,
  output byte_t    flags
);
  localparam byte_t RESET_VAL = byte_t'(1) << (SRC_POR + 1);

  byte_t flags_q;
  logic  wipe;

  assign wipe = src_ev[SRC_POR];

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst)
          flags_q[i+1] <= RESET_VAL[i+1];
        else
          flags_q[i+1] <= src_ev[i] | (flags_q[i+1] & ~clr & ~wipe);
      end
    end
  endgenerate

  always_ff @(posedge clk) flags_q[0] <= 1'b0;

  assign flags = flags_q;

  assert_por_wipe_R4: assert property (@(posedge clk) disable iff (rst)
    (src_ev == src_vec_t'(1 << SRC_POR)) |=> (flags == RESET_VAL));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (!src_ev[SRC_POR] && !clr) |=> ((flags & $past(flags)) == $past(flags)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && src_ev == '0) |=> (flags == '0));

  assert_keep_on_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && src_ev[SRC_ILOP]) |=> flags[SRC_ILOP+1]);
endmodule

// File: rtl/brk_flag_reg.sv
module brk_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_req,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= 1'b0;
    else if (set_ev)
      flag_q <= 1'b1;
    else if (clr_req)
      flag_q <= 1'b0;
  end

  assign flag = flag_q;

  assert_brk_set_R8: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag);

  assert_brk_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!set_ev && !clr_req) |=> (flag == $past(flag)));

  assert_brk_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_ev) |=> !flag);
endmodule

// File: rtl/stat_bus_dec.sv
module stat_bus_dec
  import rst_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  byte_t             wdata,
  input  byte_t             rst_flags,
  input  logic              brk_flag,
  output byte_t             rdata,
  output logic              rst_clr,
  output logic              brk_clr
);
  localparam logic [ADDR_W-1:0] BRK_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] RSR_ADDR = BASE_ADDR + 1'b1;
  localparam byte_t BRK_MASK = byte_t'(1) << BRK_BIT;

  logic hit_brk, hit_rsr;

  assign hit_brk = (addr == BRK_ADDR);
  assign hit_rsr = (addr == RSR_ADDR);

  assign rst_clr = rd && hit_rsr;
  assign brk_clr = wr && hit_brk && ((wdata & BRK_MASK) == '0);

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_rsr)
        rdata = rst_flags;
      else if (hit_brk)
        rdata = brk_flag ? BRK_MASK : '0;
    end
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !rd |-> (rdata == '0));

  assert_rsr_bit0_R3: assert property (@(posedge clk) disable iff (rst)
    (rd && hit_rsr) |-> (rdata[0] == 1'b0));

  assert_brk_other_bits_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && hit_brk) |-> ((rdata & ~BRK_MASK) == '0));
endmodule

// File: rtl/rst_brk_status.sv
module rst_brk_status
  import rst_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_por,
  input  logic              ev_pin,
  input  logic              ev_wdog,
  input  logic              ev_ilop,
  input  logic              ev_iladdr,
  input  logic              ev_modesel,
  input  logic              ev_lowv,
  input  logic              ev_brk_wait,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  src_vec_t src_ev;
  byte_t    rst_flags;
  logic     brk_flag, rst_clr, brk_clr;

  always_comb begin
    src_ev              = '0;
    src_ev[SRC_POR]     = ev_por;
    src_ev[SRC_PIN]     = ev_pin;
    src_ev[SRC_WDOG]    = ev_wdog;
    src_ev[SRC_ILOP]    = ev_ilop;
    src_ev[SRC_ILADDR]  = ev_iladdr;
    src_ev[SRC_MODESEL] = ev_modesel;
    src_ev[SRC_LOWV]    = ev_lowv;
  end

  rst_src_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .src_ev (src_ev),
    .clr    (rst_clr),
    .flags  (rst_flags)
  );

  brk_flag_reg u_brk (
    .clk     (clk),
    .rst     (rst),
    .set_ev  (ev_brk_wait),
    .clr_req (brk_clr),
    .flag    (brk_flag)
  );

  stat_bus_dec #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .rst_flags (rst_flags),
    .brk_flag  (brk_flag),
    .rdata     (bus_rdata),
    .rst_clr   (rst_clr),
    .brk_clr   (brk_clr)
  );

  assert_wr_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == BASE_ADDR + 1'b1 &&
     !ev_por && !ev_pin && !ev_wdog && !ev_ilop && !ev_iladdr &&
     !ev_modesel && !ev_lowv) |=> (rst_flags == $past(rst_flags)));
endmodule

// File: tb/tb_rst_brk_status.sv
module tb_rst_brk_status;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h40;
  localparam logic [7:0] A_BRK = BASE;
  localparam logic [7:0] A_RSR = BASE + 8'h01;

  // event vector order: {por,pin,wdog,ilop,iladdr,modesel,lowv}
  localparam logic [6:0] E_NONE = 7'b0000000;
  localparam logic [6:0] E_POR  = 7'b1000000;
  localparam logic [6:0] E_PIN  = 7'b0100000;
  localparam logic [6:0] E_WDOG = 7'b0010000;
  localparam logic [6:0] E_ILOP = 7'b0001000;
  localparam logic [6:0] E_ILAD = 7'b0000100;
  localparam logic [6:0] E_MODE = 7'b0000010;
  localparam logic [6:0] E_LOWV = 7'b0000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] ev = '0;
  logic brk = 1'b0;
  logic [7:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0, chk = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  logic [7:0] exp_q[$];
  string      req_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_brk_status #(.ADDR_W(8), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst(rst),
    .ev_por(ev[6]), .ev_pin(ev[5]), .ev_wdog(ev[4]), .ev_ilop(ev[3]),
    .ev_iladdr(ev[2]), .ev_modesel(ev[1]), .ev_lowv(ev[0]),
    .ev_brk_wait(brk),
    .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata)
  );

  // monitor: compare mid-cycle, before the edge that applies side effects
  always @(negedge clk) begin
    if (chk) begin
      if (exp_q.size() == 0) begin
        fails++; checks++;
        $display("FAIL monitor: queue empty, actual %h expected none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        checks++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", r, rdata, e);
        end
      end
    end
  end

  task automatic step(input logic [6:0] e, input logic b, input logic r,
                      input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic c, input logic [7:0] x, input string q);
    ev = e; brk = b; rd = r; wr = w; addr = a; wdata = d; chk = c;
    if (c) begin exp_q.push_back(x); req_q.push_back(q); end
    @(posedge clk); #1;
    ev = '0; brk = 1'b0; rd = 1'b0; wr = 1'b0; chk = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] e, input logic b);
    step(e, b, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "");
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] x, input string q);
    step(E_NONE, 1'b0, 1'b1, 1'b0, a, 8'h00, 1'b1, x, q);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    step(E_NONE, 1'b0, 1'b0, 1'b1, a, d, 1'b0, 8'h00, "");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    rd_chk(A_RSR, 8'h80, "R1 reset-cause after reset");
    rd_chk(A_RSR, 8'h00, "R6 cleared by previous read");
    rd_chk(A_BRK, 8'h00, "R1 break-wake after reset");

    pulse(E_PIN, 1'b0);
    rd_chk(A_RSR, 8'h40, "R3 pin at bit 6");
    pulse(E_PIN, 1'b0);
    pulse(E_WDOG, 1'b0);
    rd_chk(A_RSR, 8'h60, "R5 pin and watchdog accumulate");
    pulse(E_ILAD | E_MODE | E_LOWV, 1'b0);
    rd_chk(A_RSR, 8'h0E, "R3 iladdr/modesel/lowv bits 3..1");
    pulse(E_ILOP, 1'b0);
    rd_chk(A_RSR, 8'h10, "R3 illegal opcode at bit 4");

    pulse(E_PIN | E_WDOG, 1'b0);
    pulse(E_POR | E_LOWV, 1'b0);
    rd_chk(A_RSR, 8'h82, "R4 power-on with low-voltage wipes others");
    pulse(E_MODE, 1'b0);
    pulse(E_POR, 1'b0);
    rd_chk(A_RSR, 8'h80, "R4 power-on alone");

    pulse(E_PIN, 1'b0);
    step(E_ILOP, 1'b0, 1'b1, 1'b0, A_RSR, 8'h00, 1'b1, 8'h40, "R6 read returns pre-clear value");
    rd_chk(A_RSR, 8'h10, "R6 same-cycle event survives clear");

    pulse(E_WDOG, 1'b0);
    wr_reg(A_RSR, 8'h00);
    wr_reg(A_RSR, 8'hFF);
    rd_chk(A_RSR, 8'h20, "R7 writes to reset-cause ignored");

    pulse(E_PIN, 1'b0);
    step(E_NONE, 1'b0, 1'b0, 1'b0, A_RSR, 8'h00, 1'b1, 8'h00, "R2 no read strobe gives zero");
    rd_chk(BASE + 8'h02, 8'h00, "R2 unmapped address reads zero");
    rd_chk(A_RSR, 8'h40, "R2 unmapped read leaves state");

    pulse(E_NONE, 1'b1);
    rd_chk(A_BRK, 8'h02, "R8 break-wake flag at bit 1");
    wr_reg(A_BRK, 8'hFF);
    rd_chk(A_BRK, 8'h02, "R9 write of 1 keeps flag");
    wr_reg(A_RSR, 8'h00);
    rd_chk(A_BRK, 8'h02, "R9 zero write elsewhere keeps flag");
    wr_reg(A_BRK, 8'hFD);
    rd_chk(A_BRK, 8'h00, "R9 write of 0 clears flag");
    step(E_NONE, 1'b1, 1'b0, 1'b1, A_BRK, 8'h00, 1'b0, 8'h00, "");
    rd_chk(A_BRK, 8'h02, "R9 set wins over same-cycle clear");
    wr_reg(A_BRK, 8'h00);
    rd_chk(A_BRK, 8'h00, "R9 flag cleared again");

    pulse(E_PIN, 1'b0);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    rd_chk(A_RSR, 8'h80, "R1 re-reset restores power-on pattern");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL scoreboard: %0d left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule